// File: doc/BRIEF.md
# Watchdog Timer with Masked Reset Fan-out

This block is a countdown watchdog that, on expiry, fans reset pulses out to a set of peripherals. Software loads a reload value, enables the timer through a control register, and keeps it alive by writing a fixed key to a restart register. The counter steps down once per `tick` pulse. When it reaches zero, every peripheral whose bit is set in a 26-bit reset mask receives a fixed-length reset pulse, and a chip-wide reset pulse is raised with them.

A system-control configuration word from outside the block changes what expiry does. When bit 0 of that word is set, expiry only resets the memory controller. The chip-wide reset stays low and the control register is cleared, which stops the timer. This lets a memory bring-up sequence reset the memory controller on its own, without rebooting the chip.

Registers use 32-bit word access on one write/read port. Reads are combinational from the address.

Top module: `wdog_rstdist`

## Requirements
- R1: After reset, `periph_rst` and `sys_rst` are low, the control register reads 0, the mask reads 0x023FFFF3 and the counter reads the `RELOAD_RST` parameter (default 0x0000FFFF).
- R2: The counter (read at 0x00) drops by one on each cycle where `tick` is high, and only while control bit 0 (enable, address 0x0C) is 1. With enable at 0, `tick` leaves it unchanged.
- R3: Writing exactly 0x00004755 to 0x08 loads the counter from the reload register (0x04). Any other value written there leaves the counter unchanged.
- R4: Expiry happens on the tick that takes the counter from 1 to 0. After that the counter stays at 0 and no further expiry occurs until a restart. In normal mode the enable bit stays 1.
- R5: On a normal-mode expiry (configuration bit 0 low), each `periph_rst[i]` whose mask bit i is 1, and also `sys_rst`, go high in the cycle after the expiring clock edge. They stay high for exactly `PULSE_CYC` (4) cycles. Outputs with a mask bit of 0 stay low.
- R6: If `sysctl_cfg[0]` is 1 at expiry, only `periph_rst[2]` (the memory controller) pulses, whatever the mask says. `sys_rst` stays low, and the control register reads 0 afterwards. Bits 31:1 of `sysctl_cfg` have no effect.
- R7: Mask register bit i (0x1C, bits 25:0) selects `periph_rst[i]`. Bit 2 is the memory controller. Bits 31:26 ignore writes and read 0.
- R8: Reads of 0x08 and of unmapped addresses return 0. Writes to the counter address 0x00 are ignored.
- R9: If a valid restart write and a tick arrive in the same cycle, the restart wins. The counter takes the reload value and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the word register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| tick | input | 1 | Count-enable pulse |
| sysctl_cfg | input | 32 | System-control reset configuration; bit 0 selects memory-only expiry |
| periph_rst | output | 26 | Per-peripheral reset pulses |
| sys_rst | output | 1 | Chip-wide reset pulse |

## Verification
A wrong counter value shows up at the ports as expiry on the wrong tick. Because the bench sweeps reload values 1 to 6 and reads the counter after every tick, the error appears within one tick. A wrong action decode or mask path shows up in the first cycle after expiry: the pulse vector no longer equals the written mask (or the single memory-controller bit), or `sys_rst` has the wrong level. A mistake in the pulse counters shows up at most `PULSE_CYC` cycles later, as a pulse that is too short or too long. Walking a single one through the mask makes every lane visible on its own.

// File: rtl/wdog_rstdist_pkg.sv
package wdog_rstdist_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] A_COUNT  = 8'h00;
    localparam logic [ADDR_W-1:0] A_RELOAD = 8'h04;
    localparam logic [ADDR_W-1:0] A_KICK   = 8'h08;
    localparam logic [ADDR_W-1:0] A_CTRL   = 8'h0C;
    localparam logic [ADDR_W-1:0] A_MASK   = 8'h1C;

    localparam logic [REG_W-1:0] KICK_KEY     = 32'h0000_4755;
    localparam logic [REG_W-1:0] MASK_DEFAULT = 32'h023F_FFF3;

    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_FULL    = 2'd1,
        ACT_MEMONLY = 2'd2
    } expire_act_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  data;
    } reg_req_t;

    function automatic expire_act_e pick_action(logic expire, logic mem_sel);
        if (!expire)      return ACT_NONE;
        else if (mem_sel) return ACT_MEMONLY;
        else              return ACT_FULL;
    endfunction

    function automatic logic is_kick(reg_req_t r);
        return r.wr && (r.addr == A_KICK) && (r.data == KICK_KEY);
    endfunction

endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
    import wdog_rstdist_pkg::*;
#(
    parameter int              CNT_W      = 32,
    parameter int              NUM_PERIPH = 26,
    parameter logic [CNT_W-1:0] RELOAD_RST = CNT_W'(32'h0000_FFFF)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  reg_req_t              req,
    input  logic                  clear_ctrl_i,
    input  logic [CNT_W-1:0]      cnt_i,
    output logic [CNT_W-1:0]      reload_o,
    output logic                  en_o,
    output logic [NUM_PERIPH-1:0] mask_o,
    output logic                  kick_o,
    output logic [REG_W-1:0]      rdata_o
);

    localparam logic [NUM_PERIPH-1:0] MASK_RST = MASK_DEFAULT[NUM_PERIPH-1:0];

    logic [CNT_W-1:0]      reload_q;
    logic                  ctrl_q;
    logic [NUM_PERIPH-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= RELOAD_RST;
            ctrl_q   <= 1'b0;
            mask_q   <= MASK_RST;
        end else begin
            if (req.wr && req.addr == A_RELOAD) reload_q <= req.data[CNT_W-1:0];
            if (req.wr && req.addr == A_MASK)   mask_q   <= req.data[NUM_PERIPH-1:0];
            if (clear_ctrl_i)                        ctrl_q <= 1'b0;
            else if (req.wr && req.addr == A_CTRL)   ctrl_q <= req.data[0];
        end
    end

    always_comb begin
        case (req.addr)
            A_COUNT:  rdata_o = REG_W'(cnt_i);
            A_RELOAD: rdata_o = REG_W'(reload_q);
            A_CTRL:   rdata_o = REG_W'(ctrl_q);
            A_MASK:   rdata_o = REG_W'(mask_q);
            default:  rdata_o = '0;
        endcase
    end

    assign reload_o = reload_q;
    assign en_o     = ctrl_q;
    assign mask_o   = mask_q;
    assign kick_o   = is_kick(req);

    // Memory-only expiry overrides any same-cycle control write.
    assert_ctrl_clear_R6: assert property (@(posedge clk) disable iff (rst)
        clear_ctrl_i |=> !en_o);

    // The mask only moves on a write to its own address.
    assert_mask_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(req.wr && req.addr == A_MASK) |=> $stable(mask_o));

endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
    parameter int               CNT_W      = 32,
    parameter logic [CNT_W-1:0] RELOAD_RST = CNT_W'(32'h0000_FFFF)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             kick_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             step;

    assign step     = en_i && tick_i && (cnt_q != '0);
    assign expire_o = step && !kick_i && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= RELOAD_RST;
        else if (kick_i) cnt_q <= reload_i;
        else if (step)   cnt_q <= cnt_q - CNT_W'(1);
    end

    assign cnt_o = cnt_q;

    assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !kick_i) |=> $stable(cnt_o));

    assert_kick_loads_R3: assert property (@(posedge clk) disable iff (rst)
        kick_i |=> (cnt_o == $past(reload_i)));

    assert_expire_zero_R4: assert property (@(posedge clk) disable iff (rst)
        expire_o |=> (cnt_o == '0));

    assert_no_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (cnt_o == '0 && !kick_i) |=> (cnt_o == '0));

endmodule

// File: rtl/wdog_pulse_bank.sv
module wdog_pulse_bank #(
    parameter int LANES     = 27,
    parameter int PULSE_CYC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] trig_i,
    output logic [LANES-1:0] out_o
);

    localparam int PW = $clog2(PULSE_CYC + 1);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [PW-1:0] left_q;

        always_ff @(posedge clk) begin
            if (rst)                left_q <= '0;
            else if (trig_i[g])     left_q <= PW'(PULSE_CYC);
            else if (left_q != '0)  left_q <= left_q - PW'(1);
        end

        assign out_o[g] = (left_q != '0);

        assert_pulse_start_R5: assert property (@(posedge clk) disable iff (rst)
            trig_i[g] |=> out_o[g]);

        assert_pulse_cause_R5: assert property (@(posedge clk) disable iff (rst)
            $rose(out_o[g]) |-> $past(trig_i[g]));
    end

endmodule

// File: rtl/wdog_rstdist.sv
module wdog_rstdist
    import wdog_rstdist_pkg::*;
#(
    parameter int               CNT_W      = 32,
    parameter int               NUM_PERIPH = 26,
    parameter int               PULSE_CYC  = 4,
    parameter int               MEM_IDX    = 2,
    parameter logic [CNT_W-1:0] RELOAD_RST = CNT_W'(32'h0000_FFFF)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [7:0]            reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic                  tick,
    input  logic [31:0]           sysctl_cfg,
    output logic [NUM_PERIPH-1:0] periph_rst,
    output logic                  sys_rst
);

    localparam int                    LANES       = NUM_PERIPH + 1;
    localparam logic [NUM_PERIPH-1:0] MEM_ONEHOT  = NUM_PERIPH'(1) << MEM_IDX;

    reg_req_t              req;
    logic [CNT_W-1:0]      reload, cnt;
    logic                  en, kick, expire, clear_ctrl;
    logic [NUM_PERIPH-1:0] mask;
    logic [LANES-1:0]      trig, pulses;
    expire_act_e           act;
    logic                  unused_cfg;

    assign req        = '{wr: reg_wr, addr: reg_addr, data: reg_wdata};
    assign unused_cfg = ^sysctl_cfg[31:1];

    wdog_regfile #(
        .CNT_W      (CNT_W),
        .NUM_PERIPH (NUM_PERIPH),
        .RELOAD_RST (RELOAD_RST)
    ) u_regs (
        .clk          (clk),
        .rst          (rst),
        .req          (req),
        .clear_ctrl_i (clear_ctrl),
        .cnt_i        (cnt),
        .reload_o     (reload),
        .en_o         (en),
        .mask_o       (mask),
        .kick_o       (kick),
        .rdata_o      (reg_rdata)
    );

    wdog_countdown #(
        .CNT_W      (CNT_W),
        .RELOAD_RST (RELOAD_RST)
    ) u_count (
        .clk      (clk),
        .rst      (rst),
        .en_i     (en),
        .tick_i   (tick),
        .kick_i   (kick),
        .reload_i (reload),
        .cnt_o    (cnt),
        .expire_o (expire)
    );

    assign act        = pick_action(expire, sysctl_cfg[0]);
    assign clear_ctrl = (act == ACT_MEMONLY);

    always_comb begin
        case (act)
            ACT_FULL:    trig = {1'b1, mask};
            ACT_MEMONLY: trig = {1'b0, MEM_ONEHOT};
            default:     trig = '0;
        endcase
    end

    wdog_pulse_bank #(
        .LANES     (LANES),
        .PULSE_CYC (PULSE_CYC)
    ) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .trig_i (trig),
        .out_o  (pulses)
    );

    assign periph_rst = pulses[NUM_PERIPH-1:0];
    assign sys_rst    = pulses[NUM_PERIPH];

    assert_full_sys_R5: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_FULL) |=> sys_rst);

    assert_memonly_nosys_R6: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_MEMONLY && !sys_rst) |=> !sys_rst);

    assert_memonly_hit_R6: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_MEMONLY) |=> periph_rst[MEM_IDX]);

    always_comb begin
        if (!rst && reg_addr == A_MASK)
            assert_resv_zero_R7: assert (reg_rdata[31:NUM_PERIPH] == '0);
    end

endmodule

// File: tb/wdog_rstdist_tb.sv
module wdog_rstdist_tb;

    localparam logic [7:0]  A_COUNT  = 8'h00;
    localparam logic [7:0]  A_RELOAD = 8'h04;
    localparam logic [7:0]  A_KICK   = 8'h08;
    localparam logic [7:0]  A_CTRL   = 8'h0C;
    localparam logic [7:0]  A_MASK   = 8'h1C;
    localparam logic [31:0] KEY      = 32'h0000_4755;
    localparam logic [31:0] ALL26    = 32'h03FF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tick = 1'b0;
    logic [31:0] sysctl_cfg = '0;
    logic [25:0] periph_rst;
    logic        sys_rst;

    int vecs = 0;
    int errs = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    wdog_rstdist u_dut (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .tick       (tick),
        .sysctl_cfg (sysctl_cfg),
        .periph_rst (periph_rst),
        .sys_rst    (sys_rst)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    // Expiry after a 2-tick countdown; pulses checked over their whole length.
    task automatic run_expiry(logic [31:0] mask, bit mem);
        logic [31:0] v, exp_p;
        wr(A_MASK, mask);
        wr(A_RELOAD, 32'd2);
        wr(A_KICK, KEY);
        wr(A_CTRL, 32'd1);
        sysctl_cfg = mem ? 32'hFFFF_FFFF : 32'hFFFF_FFFE;
        do_tick();
        rd(A_COUNT, v);
        chk("R2 count after one tick", v, 32'd1);
        chk("R5 no pulse before expiry", 32'(periph_rst), 32'd0);
        do_tick();
        exp_p = mem ? 32'h0000_0004 : (mask & ALL26);
        for (int k = 0; k < 4; k++) begin
            chk(mem ? "R6 memory-only pulse" : "R5 masked pulse", 32'(periph_rst), exp_p);
            chk(mem ? "R6 no system reset" : "R5 system reset", 32'(sys_rst), mem ? 32'd0 : 32'd1);
            @(negedge clk);
        end
        chk("R5 pulse released", 32'(periph_rst), 32'd0);
        chk("R5 system reset released", 32'(sys_rst), 32'd0);
        rd(A_CTRL, v);
        chk(mem ? "R6 control cleared" : "R4 enable kept", v, mem ? 32'd0 : 32'd1);
        do_tick();
        do_tick();
        chk("R4 no second expiry", 32'(periph_rst) | 32'(sys_rst), 32'd0);
        rd(A_COUNT, v);
        chk("R4 counter stays zero", v, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog timeout actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 periph_rst low", 32'(periph_rst), 32'd0);
        chk("R1 sys_rst low", 32'(sys_rst), 32'd0);
        rd(A_MASK, v);  chk("R1 mask default", v, 32'h023F_FFF3);
        rd(A_CTRL, v);  chk("R1 control zero", v, 32'd0);
        rd(A_COUNT, v); chk("R1 counter reload default", v, 32'h0000_FFFF);

        // R8 unmapped and write-only / read-only addresses
        rd(A_KICK, v);  chk("R8 restart reads zero", v, 32'd0);
        for (int a = 8'h10; a < 8'h1C; a += 4) begin
            rd(8'(a), v); chk("R8 unmapped reads zero", v, 32'd0);
        end
        rd(8'hFC, v);   chk("R8 unmapped reads zero", v, 32'd0);
        wr(A_COUNT, 32'h1234);
        rd(A_COUNT, v); chk("R8 counter write ignored", v, 32'h0000_FFFF);

        // R7 reserved mask bits
        wr(A_MASK, 32'hFFFF_FFFF);
        rd(A_MASK, v);  chk("R7 reserved bits zero", v, ALL26);

        // R3 only the exact key restarts
        wr(A_RELOAD, 32'd9);
        wr(A_KICK, 32'h0000_4754); rd(A_COUNT, v); chk("R3 bad key ignored", v, 32'h0000_FFFF);
        wr(A_KICK, 32'h0000_4756); rd(A_COUNT, v); chk("R3 bad key ignored", v, 32'h0000_FFFF);
        wr(A_KICK, 32'h0001_4755); rd(A_COUNT, v); chk("R3 bad key ignored", v, 32'h0000_FFFF);
        wr(A_KICK, 32'h0000_0000); rd(A_COUNT, v); chk("R3 bad key ignored", v, 32'h0000_FFFF);
        wr(A_KICK, KEY);           rd(A_COUNT, v); chk("R3 key reloads", v, 32'd9);

        // R2 disabled counter ignores ticks
        wr(A_CTRL, 32'd0);
        for (int k = 0; k < 3; k++) do_tick();
        rd(A_COUNT, v); chk("R2 hold while disabled", v, 32'd9);

        // R2/R4 reload sweep: expiry exactly on the n-th tick
        for (int n = 1; n <= 6; n++) begin
            wr(A_MASK, 32'd1);
            wr(A_RELOAD, 32'(n));
            wr(A_KICK, KEY);
            wr(A_CTRL, 32'd1);
            sysctl_cfg = 32'd0;
            for (int k = 1; k < n; k++) begin
                do_tick();
                chk("R4 no early expiry", 32'(periph_rst), 32'd0);
                rd(A_COUNT, v); chk("R2 decrement", v, 32'(n - k));
            end
            do_tick();
            chk("R4 expiry on tick to zero", 32'(periph_rst), 32'd1);
            repeat (5) @(negedge clk);
        end

        // R9 restart beats a same-cycle tick
        wr(A_MASK, 32'd1);
        wr(A_RELOAD, 32'd1);
        wr(A_KICK, KEY);
        wr(A_CTRL, 32'd1);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_KICK; reg_wdata = KEY; tick = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tick = 1'b0;
        chk("R9 no expiry on restart", 32'(periph_rst) | 32'(sys_rst), 32'd0);
        rd(A_COUNT, v); chk("R9 counter reloaded", v, 32'd1);
        do_tick();
        chk("R9 later expiry", 32'(periph_rst), 32'd1);
        repeat (5) @(negedge clk);

        // R5/R7 mask sweep in normal mode
        run_expiry(32'h023F_FFF3, 1'b0);
        run_expiry(32'd0, 1'b0);
        run_expiry(32'hFFFF_FFFF, 1'b0);
        for (int b = 0; b < 26; b++) run_expiry(32'd1 << b, 1'b0);

        // R6 memory-only mode, mask irrelevant
        run_expiry(32'd0, 1'b1);
        run_expiry(ALL26, 1'b1);
        run_expiry(32'h023F_FFF3, 1'b1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule